// File: doc/BRIEF.md
# SDRAM Refresh and Self-Refresh Sequencer

This block is the refresh manager of a single-data-rate SDRAM controller. An interval timer, whose period in clock cycles is derived from the clock period and the required average refresh spacing, adds one owed refresh at each expiry. The owed count saturates. While refreshes are owed, the block raises a request to the main command arbiter. Once the arbiter grants the bus, the block precharges all banks and waits out the precharge time. It then issues AUTO REFRESH, keeps the bus quiet for the refresh cycle time, and returns the bus with a one-cycle done pulse. When postponed refreshes pile up to a threshold, an urgency flag tells the arbiter to raise its priority.

A low-power request uses the same path. The block requests the bus, precharges, and then issues the refresh command with the clock enable low, which places the device in self refresh. The clock enable stays low until the request is withdrawn, and in any case for a minimum residency. On exit the block raises the clock enable, drives NOPs for the exit time (never fewer than two clocks), and issues an AUTO REFRESH straight away. It then restarts the interval timer from that command and hands the bus back.

Top module: `sdrf_refresh_seq`

## Requirements
- R1: While reset is asserted and after its release, the outputs are clock enable high, command NOP ({cs_n,ras_n,cas_n,we_n} = 0111), A10 low, and ref_req, busy, ref_done and ref_urgent low.
- R2: The refresh interval is REFI_CYC = REFI_PS / CLK_PS cycles. The first ref_req rises one interval (give or take a few cycles) after reset release, with no grant given.
- R3: When ref_req is high and arb_grant is seen, the next cycle carries PRECHARGE (0010) with sdr_a10 high, which selects all banks.
- R4: AUTO REFRESH (0001, clock enable high) comes exactly T_RP cycles after the PRECHARGE, with only NOP in between.
- R5: After an AUTO REFRESH, only NOP is driven for T_RFC cycles. ref_done pulses for one cycle T_RFC cycles after the command, and in the next cycle busy and ref_req are both low. The block never issues a command other than those required here.
- R6: Owed refreshes saturate at OWED_MAX. After a long postponement, a granted burst performs exactly OWED_MAX refreshes and then drops ref_req.
- R7: ref_urgent is high exactly while the owed count is at least POSTPONE_LIM.
- R8: If lp_req is high when the grant is taken, the PRECHARGE is followed T_RP cycles later by the refresh encoding (0001) with the clock enable low.
- R9: In self refresh the clock enable stays low and only NOP is driven, for at least T_RAS cycles from the entry command, even if lp_req drops earlier.
- R10: On exit, the clock enable rises with NOP, NOP is held for max(T_XSR,2) cycles, and then AUTO REFRESH with the clock enable high follows. ref_done comes T_RFC cycles after that.
- R11: Self refresh clears the owed count and holds the timer. The next ref_req rises one interval (give or take a few cycles) after the exit AUTO REFRESH.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lp_req | input | 1 | Low-power request; high to enter and stay in self refresh |
| arb_grant | input | 1 | Bus grant from the main arbiter, held until ref_done |
| ref_req | output | 1 | Bus request to the arbiter |
| ref_urgent | output | 1 | Postponed refreshes reached the threshold |
| ref_done | output | 1 | One-cycle pulse: bus released |
| busy | output | 1 | Block is driving the SDRAM command bus |
| sdr_cs_n | output | 1 | Chip select, active low |
| sdr_ras_n | output | 1 | Row strobe, active low |
| sdr_cas_n | output | 1 | Column strobe, active low |
| sdr_we_n | output | 1 | Write enable, active low |
| sdr_cke | output | 1 | Clock enable |
| sdr_a10 | output | 1 | All-bank select during precharge |

## Verification
An off-by-one in the shared wait counter shows at the command pins within the same sequence. The AUTO REFRESH, the clock-enable rise or the done pulse lands one cycle away from its exact expected cycle, so the scoreboard reports it tens of cycles after the grant. A fault in the owed counter or its saturation stays hidden until a postponed burst is granted. It then shows as the wrong number of back-to-back refreshes, or as the urgency flag in the wrong state, several intervals into the run. A timer that keeps running or keeps its debt through self refresh shows only as a request arriving too early after exit, up to one interval later.

// File: rtl/sdrf_pkg.sv
package sdrf_pkg;

   // sequencer states
   typedef enum logic [3:0] {
      ST_IDLE = 4'd0,
      ST_REQ  = 4'd1,
      ST_PRE  = 4'd2,
      ST_WRP  = 4'd3,
      ST_AREF = 4'd4,
      ST_WRFC = 4'd5,
      ST_DONE = 4'd6,
      ST_SREN = 4'd7,
      ST_SRES = 4'd8,
      ST_SRX  = 4'd9
   } sdrf_state_e;

   // command codes as {cs_n, ras_n, cas_n, we_n}
   localparam logic [3:0] CMD_NOP   = 4'b0111;
   localparam logic [3:0] CMD_PRE   = 4'b0010;
   localparam logic [3:0] CMD_AREF  = 4'b0001;
   localparam logic [3:0] CMD_DESEL = 4'b1111;

   function automatic int unsigned umax(input int unsigned a, input int unsigned b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/sdrf_wait_counter.sv
module sdrf_wait_counter #(
   parameter int unsigned CW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] load_val,
   output logic          expired
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              cnt_q <= '0;
      else if (load)           cnt_q <= load_val;
      else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/sdrf_interval_timer.sv
module sdrf_interval_timer #(
   parameter  int unsigned REFI_CYC     = 1041,
   parameter  int unsigned OWED_MAX     = 3,
   parameter  int unsigned POSTPONE_LIM = 2,
   localparam int unsigned TW           = $clog2(REFI_CYC),
   localparam int unsigned OW           = $clog2(OWED_MAX + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hold,
   input  logic          served,
   output logic [OW-1:0] owed,
   output logic          urgent
);

   logic [TW-1:0] tmr_q;
   logic [OW-1:0] owed_q;
   logic          tick, inc, dec;

   assign tick = (tmr_q == '0);
   assign dec  = served && (owed_q != '0);
   assign inc  = tick && ((owed_q != OW'(OWED_MAX)) || dec);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tmr_q  <= TW'(REFI_CYC - 1);
         owed_q <= '0;
      end else if (hold) begin
         tmr_q  <= TW'(REFI_CYC - 1);
         owed_q <= '0;
      end else begin
         tmr_q <= tick ? TW'(REFI_CYC - 1) : tmr_q - 1'b1;
         if (inc && !dec)      owed_q <= owed_q + 1'b1;
         else if (dec && !inc) owed_q <= owed_q - 1'b1;
      end
   end

   assign owed   = owed_q;
   assign urgent = (owed_q >= OW'(POSTPONE_LIM));

   // debt never exceeds its ceiling and is not lost at the ceiling
   assert_owed_saturates_R6 : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && (owed_q == OW'(OWED_MAX)) && !served) |=> (owed_q == OW'(OWED_MAX)));

   // each interval expiry adds one owed refresh below the ceiling
   assert_tick_adds_R2 : assert property (@(posedge clk) disable iff (!rst_n)
      (!hold && tick && !served && (owed_q < OW'(OWED_MAX))) |=> (owed_q == $past(owed_q) + 1'b1));

endmodule

// File: rtl/sdrf_seq_fsm.sv
module sdrf_seq_fsm
   import sdrf_pkg::*;
#(
   parameter int unsigned T_RP    = 3,
   parameter int unsigned T_RFC   = 10,
   parameter int unsigned T_RAS   = 6,
   parameter int unsigned XSR_EFF = 10,
   parameter int unsigned CW      = 4
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       owed_nz,
   input  logic       lp_req,
   input  logic       arb_grant,
   output logic [3:0] cmd,
   output logic       cke,
   output logic       a10,
   output logic       busy,
   output logic       ref_req,
   output logic       ref_done,
   output logic       served,
   output logic       sr_active
);

   sdrf_state_e   state_q, state_d;
   logic          sr_q;
   logic          ld, expired;
   logic [CW-1:0] ld_val;

   sdrf_wait_counter #(.CW(CW)) wait_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (ld),
      .load_val (ld_val),
      .expired  (expired)
   );

   always_comb begin
      ld     = 1'b0;
      ld_val = '0;
      case (state_q)
         ST_PRE:  begin ld = 1'b1; ld_val = CW'(T_RP - 2);  end
         ST_AREF: begin ld = 1'b1; ld_val = CW'(T_RFC - 2); end
         ST_SREN: begin ld = 1'b1; ld_val = CW'(T_RAS - 2); end
         ST_SRES: if (expired && !lp_req) begin ld = 1'b1; ld_val = CW'(XSR_EFF - 1); end
         default: ;
      endcase
   end

   always_comb begin
      state_d = state_q;
      case (state_q)
         ST_IDLE: if (owed_nz || lp_req) state_d = ST_REQ;
         ST_REQ:  if (arb_grant) state_d = ST_PRE;
         ST_PRE:  state_d = ST_WRP;
         ST_WRP:  if (expired) state_d = sr_q ? ST_SREN : ST_AREF;
         ST_AREF: state_d = ST_WRFC;
         ST_WRFC: if (expired) state_d = ST_DONE;
         ST_DONE: state_d = ST_IDLE;
         ST_SREN: state_d = ST_SRES;
         ST_SRES: if (expired && !lp_req) state_d = ST_SRX;
         ST_SRX:  if (expired) state_d = ST_AREF;
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         sr_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (state_q == ST_REQ && arb_grant) sr_q <= lp_req;
      end
   end

   always_comb begin
      cmd = CMD_NOP;
      cke = 1'b1;
      a10 = 1'b0;
      case (state_q)
         ST_PRE:  begin cmd = CMD_PRE; a10 = 1'b1; end
         ST_AREF: cmd = CMD_AREF;
         ST_SREN: begin cmd = CMD_AREF; cke = 1'b0; end
         ST_SRES: cke = 1'b0;
         default: ;
      endcase
   end

   assign busy      = !(state_q == ST_IDLE || state_q == ST_REQ);
   assign ref_req   = !(state_q == ST_IDLE || state_q == ST_DONE);
   assign ref_done  = (state_q == ST_DONE);
   assign served    = (state_q == ST_AREF);
   assign sr_active = (state_q == ST_SREN) || (state_q == ST_SRES) || (state_q == ST_SRX);

   assert_grant_starts_pre_R3 : assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_REQ && arb_grant) |=> (cmd == CMD_PRE && a10));

   assert_pre_then_nop_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_PRE) |=> (cmd == CMD_NOP));

   assert_done_releases_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      ref_done |=> (!busy && !ref_req));

endmodule

// File: rtl/sdrf_refresh_seq.sv
module sdrf_refresh_seq
   import sdrf_pkg::*;
#(
   parameter int unsigned CLK_PS       = 7500,
   parameter int unsigned REFI_PS      = 7810000,
   parameter int unsigned T_RP         = 3,
   parameter int unsigned T_RFC        = 10,
   parameter int unsigned T_RAS        = 6,
   parameter int unsigned T_XSR        = 10,
   parameter int unsigned OWED_MAX     = 3,
   parameter int unsigned POSTPONE_LIM = 2,
   parameter bit          IDLE_NOP     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lp_req,
   input  logic arb_grant,
   output logic ref_req,
   output logic ref_urgent,
   output logic ref_done,
   output logic busy,
   output logic sdr_cs_n,
   output logic sdr_ras_n,
   output logic sdr_cas_n,
   output logic sdr_we_n,
   output logic sdr_cke,
   output logic sdr_a10
);

   localparam int unsigned REFI_CYC = REFI_PS / CLK_PS;
   localparam int unsigned XSR_EFF  = (T_XSR < 2) ? 2 : T_XSR;
   localparam int unsigned MAXW     = umax(umax(T_RP, T_RFC), umax(T_RAS, XSR_EFF));
   localparam int unsigned CW       = $clog2(MAXW + 1);
   localparam int unsigned OW       = $clog2(OWED_MAX + 1);
   localparam int unsigned GW       = $clog2(MAXW + 2);

   // elaboration-time parameter checks
   if (REFI_CYC < 16)                begin : g_chk_refi  $error("refresh interval too short"); end
   if (T_RP < 2 || T_RFC < 2)        begin : g_chk_tim   $error("T_RP and T_RFC must be >= 2"); end
   if (T_RAS < 2)                    begin : g_chk_ras   $error("T_RAS must be >= 2"); end
   if (OWED_MAX < 1)                 begin : g_chk_owed  $error("OWED_MAX must be >= 1"); end
   if (POSTPONE_LIM < 1 || POSTPONE_LIM > OWED_MAX)
                                     begin : g_chk_plim  $error("POSTPONE_LIM out of range"); end

   logic [OW-1:0] owed;
   logic [3:0]    fsm_cmd, cmd_out;
   logic          served, sr_active, fsm_cke, fsm_a10, bus_own;

   sdrf_interval_timer #(
      .REFI_CYC     (REFI_CYC),
      .OWED_MAX     (OWED_MAX),
      .POSTPONE_LIM (POSTPONE_LIM)
   ) timer_i (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold   (sr_active),
      .served (served),
      .owed   (owed),
      .urgent (ref_urgent)
   );

   sdrf_seq_fsm #(
      .T_RP    (T_RP),
      .T_RFC   (T_RFC),
      .T_RAS   (T_RAS),
      .XSR_EFF (XSR_EFF),
      .CW      (CW)
   ) fsm_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .owed_nz   (owed != '0),
      .lp_req    (lp_req),
      .arb_grant (arb_grant),
      .cmd       (fsm_cmd),
      .cke       (fsm_cke),
      .a10       (fsm_a10),
      .busy      (busy),
      .ref_req   (ref_req),
      .ref_done  (ref_done),
      .served    (served),
      .sr_active (sr_active)
   );

   assign bus_own = busy;

   // idle-cycle encoding variant
   if (IDLE_NOP) begin : g_idle_nop
      assign cmd_out = bus_own ? fsm_cmd : CMD_NOP;
   end else begin : g_idle_desel
      assign cmd_out = bus_own ? fsm_cmd : CMD_DESEL;
   end

   assign {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} = cmd_out;
   assign sdr_cke = fsm_cke;
   assign sdr_a10 = fsm_a10;

   // pin-level spacing monitors for the assertions below
   logic [GW-1:0] pre_gap_q, rfc_gap_q, low_run_q, rise_gap_q;
   logic          cke_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_gap_q  <= '1;
         rfc_gap_q  <= '1;
         low_run_q  <= '0;
         rise_gap_q <= '1;
         cke_q      <= 1'b1;
      end else begin
         cke_q <= sdr_cke;
         if (cmd_out == CMD_PRE)                 pre_gap_q <= GW'(1);
         else if (pre_gap_q != '1)               pre_gap_q <= pre_gap_q + 1'b1;
         if (cmd_out == CMD_AREF && sdr_cke)     rfc_gap_q <= GW'(1);
         else if (rfc_gap_q != '1)               rfc_gap_q <= rfc_gap_q + 1'b1;
         if (!sdr_cke)                           low_run_q <= (low_run_q != '1) ? low_run_q + 1'b1 : low_run_q;
         else                                    low_run_q <= '0;
         if (sdr_cke && !cke_q)                  rise_gap_q <= GW'(1);
         else if (rise_gap_q != '1)              rise_gap_q <= rise_gap_q + 1'b1;
      end
   end

   assert_rp_spacing_R4 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == CMD_AREF) |-> (pre_gap_q >= GW'(T_RP)));

   assert_rfc_quiet_R5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == CMD_PRE || cmd_out == CMD_AREF) |-> (rfc_gap_q >= GW'(T_RFC)));

   assert_entry_is_refresh_R8 : assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sdr_cke) |-> (cmd_out == CMD_AREF));

   assert_sr_quiet_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sdr_cke && !$fell(sdr_cke)) |-> (cmd_out == CMD_NOP));

   assert_residency_R9 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sdr_cke) |-> (low_run_q >= GW'(T_RAS)));

   assert_exit_nops_R10 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_out == CMD_AREF && sdr_cke) |-> (rise_gap_q >= GW'(XSR_EFF)));

endmodule

// File: tb/sdrf_refresh_seq_tb_top.sv
module sdrf_refresh_seq_tb_top;

   localparam int unsigned TRP   = 3;
   localparam int unsigned TRFC  = 7;
   localparam int unsigned TRAS  = 5;
   localparam int unsigned TXSR  = 1;
   localparam int unsigned XSR_E = 2;     // floor of two NOP clocks applies
   localparam int unsigned REFI  = 100;   // 1_000_000 ps / 10_000 ps
   localparam int unsigned OMAX  = 3;
   localparam int unsigned PLIM  = 2;

   localparam logic [3:0] C_NOP  = 4'b0111;
   localparam logic [3:0] C_PRE  = 4'b0010;
   localparam logic [3:0] C_AREF = 4'b0001;

   logic clk = 1'b0, rst_n = 1'b0, lp_req = 1'b0, arb_grant = 1'b0;
   logic ref_req, ref_urgent, ref_done, busy;
   logic sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_cke, sdr_a10;

   always #5 clk = ~clk;

   sdrf_refresh_seq #(
      .CLK_PS(10000), .REFI_PS(1000000), .T_RP(TRP), .T_RFC(TRFC), .T_RAS(TRAS),
      .T_XSR(TXSR), .OWED_MAX(OMAX), .POSTPONE_LIM(PLIM), .IDLE_NOP(1'b1)
   ) dut_i (
      .clk(clk), .rst_n(rst_n), .lp_req(lp_req), .arb_grant(arb_grant),
      .ref_req(ref_req), .ref_urgent(ref_urgent), .ref_done(ref_done), .busy(busy),
      .sdr_cs_n(sdr_cs_n), .sdr_ras_n(sdr_ras_n), .sdr_cas_n(sdr_cas_n), .sdr_we_n(sdr_we_n),
      .sdr_cke(sdr_cke), .sdr_a10(sdr_a10)
   );

   int unsigned cyc = 0;
   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   int checks = 0, fails = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input int unsigned act, input int unsigned expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
      end
   endtask

   // scoreboard of expected bus events
   typedef struct {
      logic [3:0]  cmd;
      logic        cke;
      logic        a10;
      int unsigned at;
      string       req;
   } ev_t;
   ev_t exp_q[$];

   task automatic push_ev(input logic [3:0] c, input logic k, input logic a,
                          input int unsigned at, input string req);
      ev_t e;
      e.cmd = c; e.cke = k; e.a10 = a; e.at = at; e.req = req;
      exp_q.push_back(e);
   endtask

   bit   mon_en = 1'b0;
   logic prev_cke = 1'b1;
   always @(negedge clk) begin
      logic [3:0] c;
      ev_t e;
      if (mon_en) begin
         c = {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n};
         if (c != C_NOP || sdr_cke != prev_cke) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R5", "unexpected bus event cmd", int'(c), int'(C_NOP));
            end else begin
               e = exp_q.pop_front();
               checks++;
               if (c != e.cmd || sdr_cke != e.cke || sdr_a10 != e.a10 || cyc != e.at) begin
                  fails++;
                  $display("FAIL %s event: actual cmd=%b cke=%b a10=%b @%0d expected cmd=%b cke=%b a10=%b @%0d",
                           e.req, c, sdr_cke, sdr_a10, cyc, e.cmd, e.cke, e.a10, e.at);
               end
            end
         end
         prev_cke = sdr_cke;
      end
   end

   task automatic wait_req(input int unsigned lim);
      int unsigned n = 0;
      @(negedge clk);
      while (!ref_req && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_done(input int unsigned lim);
      int unsigned n = 0;
      while (!ref_done && n < lim) begin
         @(negedge clk);
         n++;
      end
   endtask

   task automatic wait_until(input int unsigned t);
      while (cyc < t) @(negedge clk);
   endtask

   // one periodic refresh: grant, expect PRE then AREF, check release
   task automatic do_refresh();
      int unsigned n;
      wait_req(2 * REFI + 20);
      chk(ref_req && !busy, "R3", "request pending, bus not taken", busy, 0);
      n = cyc;
      arb_grant = 1'b1;
      push_ev(C_PRE,  1'b1, 1'b1, n + 1, "R3");
      push_ev(C_AREF, 1'b1, 1'b0, n + 1 + TRP, "R4");
      @(negedge clk);
      wait_done(60);
      chk(ref_done && cyc == n + 1 + TRP + TRFC, "R5", "done cycle", cyc, n + 1 + TRP + TRFC);
      arb_grant = 1'b0;
      @(negedge clk);
      chk(!busy && !ref_req, "R5", "released after done", {busy, ref_req}, 0);
   endtask

   // self refresh: enter, hold lp_req for hold_cyc after entry, exit
   task automatic sr_cycle(input int unsigned hold_cyc, output int unsigned aref_at);
      int unsigned n, s, m, x;
      lp_req = 1'b1;
      wait_req(40);
      n = cyc;
      arb_grant = 1'b1;
      s = n + 1 + TRP;
      push_ev(C_PRE,  1'b1, 1'b1, n + 1, "R3");
      push_ev(C_AREF, 1'b0, 1'b0, s, "R8");
      wait_until(s + hold_cyc);
      chk(!sdr_cke && busy, "R9", "clock enable low in self refresh", sdr_cke, 0);
      m = cyc;
      lp_req = 1'b0;
      x = ((m > s + TRAS - 1) ? m : s + TRAS - 1) + 1;
      push_ev(C_NOP,  1'b1, 1'b0, x, "R9");
      push_ev(C_AREF, 1'b1, 1'b0, x + XSR_E, "R10");
      @(negedge clk);
      wait_done(REFI);
      chk(ref_done && cyc == x + XSR_E + TRFC, "R10", "done after exit refresh", cyc, x + XSR_E + TRFC);
      arb_grant = 1'b0;
      aref_at = x + XSR_E;
   endtask

   // timer restarts from the exit refresh with no debt carried
   task automatic check_restart(input int unsigned a);
      bit early = 1'b0;
      while (cyc < a + REFI - 3) begin
         @(negedge clk);
         if (ref_req) early = 1'b1;
      end
      chk(!early, "R11", "no request before interval after exit", early, 0);
      wait_req(20);
      chk(ref_req && cyc <= a + REFI + 4, "R11", "request one interval after exit", cyc, a + REFI + 1);
   endtask

   initial begin
      int unsigned r, cnt, a;
      bit more;
      repeat (4) @(negedge clk);
      chk({sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n} == C_NOP && sdr_cke && !sdr_a10,
          "R1", "bus in reset", {sdr_cs_n, sdr_ras_n, sdr_cas_n, sdr_we_n, sdr_cke, sdr_a10}, 6'b011110);
      chk(!ref_req && !busy && !ref_done && !ref_urgent, "R1", "handshake in reset",
          {ref_req, busy, ref_done, ref_urgent}, 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);
      chk(!ref_req && !busy && sdr_cke, "R1", "idle after reset", {ref_req, busy, sdr_cke}, 1);

      // first request after one interval; postpone to build up debt
      wait_req(REFI + 20);
      r = cyc;
      chk(ref_req && r >= REFI - 2 && r <= REFI + 4, "R2", "first request cycle", r, REFI + 1);
      chk(!ref_urgent, "R7", "one owed is not urgent", ref_urgent, 0);
      wait_until(r + REFI + 5);
      chk(ref_urgent, "R7", "two owed is urgent", ref_urgent, 1);
      wait_until(r + 5 * REFI + 5);
      chk(ref_urgent && ref_req, "R6", "still owed after long postponement", {ref_urgent, ref_req}, 3);

      // grant the burst; the debt is capped
      cnt = 0;
      more = 1'b1;
      while (more && cnt < 10) begin
         do_refresh();
         cnt++;
         more = 1'b0;
         for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (ref_req) more = 1'b1;
         end
      end
      chk(cnt == OMAX, "R6", "refreshes in postponed burst", cnt, OMAX);
      chk(!ref_urgent, "R7", "urgency cleared after burst", ref_urgent, 0);

      // ordinary periodic refresh
      do_refresh();

      // self refresh released early: residency floor applies
      sr_cycle(1, a);
      check_restart(a);
      do_refresh();

      // self refresh held longer than an interval: timer frozen
      sr_cycle(3 * REFI, a);
      check_restart(a);
      do_refresh();

      repeat (5) @(negedge clk);
      chk(exp_q.size() == 0, "R5", "expected events left", exp_q.size(), 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL R2 watchdog: actual %0d expected %0d cycles", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule